// File: doc/BRIEF.md
# Longword Integer Operation Unit

This unit is the execution stage slice of a 32-bit register-based processor that handles a group of longword, word and byte integer operations. Decode hands it two operands (`src`, `dst`), a 3-bit operation code, the current condition-code bits and a condition-true flag. When `in_valid` is high, the unit computes the new destination value and the new condition codes and captures both in registers. `out_valid` pulses one cycle later.

The operations are bitwise complement, inclusive OR, subtract, subtract with extend, halfword exchange, byte set-on-condition, byte test-and-set and overflow saturation. Fetch, address generation, memory access and decode sit outside the unit. An immediate OR is issued by placing the immediate on `src`.

Condition codes travel as a 5-bit vector: bit 4 is X, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. Operation codes are: 0 complement, 1 OR, 2 subtract, 3 subtract with extend, 4 halfword exchange, 5 set-on-condition, 6 test-and-set, 7 saturate.

Top module: `long_int_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first cycle after it is released, `out_valid`, `result` and `cc_out` are all zero.
- R2: A cycle with `in_valid` high causes `out_valid` to be high in the next cycle, carrying that operation's `result` and `cc_out`. A cycle with `in_valid` low causes `out_valid` to be low in the next cycle, and `result` and `cc_out` keep their previous values.
- R3: Op 0 gives `~dst`. Op 1 gives `src | dst`.
- R4: Op 2 gives `dst - src` modulo 2^32. N is result bit 31. Z is set when the result is zero. V is set on signed overflow. C and X are both set to the borrow, which is 1 when src > dst as unsigned values.
- R5: Op 3 gives `dst - src - X`. N, V, C and X follow the rules of R4, with the borrow taken over the full src + X. Z is cleared when the result is nonzero and otherwise keeps its input value.
- R6: Op 4 gives `{dst[15:0], dst[31:16]}`.
- R7: Op 5 gives `{dst[31:8], 8'hFF}` when `cond_true` is 1 and `{dst[31:8], 8'h00}` when it is 0. All condition codes pass through unchanged.
- R8: Op 6 gives `dst` with bit 7 forced to 1 and bits 31:8 kept. N is the original `dst[7]`. Z is set when the original `dst[7:0]` is zero.
- R9: Op 7 with input V = 0 gives `dst` unchanged. With V = 1, it gives 0x80000000 when `dst[31]` is 0 and 0x7FFFFFFF when `dst[31]` is 1. All condition codes pass through unchanged.
- R10: For ops 0, 1, 4 and 6, V and C are cleared and X keeps its input value. For ops 0, 1 and 4, N and Z are taken from the 32-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 to 7) |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| cc_in | input | 5 | Current condition codes {X,N,Z,V,C} |
| cond_true | input | 1 | Condition result for set-on-condition |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered destination value |
| cc_out | output | 5 | Registered condition codes {X,N,Z,V,C} |

## Verification
The bench builds the unit with its default width W = 32. At this width, the operand values at the sign boundary can be reached directly: 0x80000000 and 0x7FFFFFFF for signed overflow and saturation, and all-zero and all-one words for the borrow and for sticky Z in subtract with extend. Randomly chosen operands and flags are mixed with directed cases that place byte bit 7 and bit 31 on each side of their decision points.

// File: rtl/long_int_unit.sv
module long_int_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic [4:0]   cc_in,
  input  logic         cond_true,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [4:0]   cc_out
);
  localparam int H = W / 2;
  localparam int XB = 4, NB = 3, ZB = 2, VB = 1, CB = 0;
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic          use_x;
  logic [W:0]    diff;
  logic [W-1:0]  res_n;
  logic [4:0]    cc_n;
  logic          ovf;

  assign use_x = (op == 3'd3);
  assign diff  = {1'b0, dst} - {1'b0, src} - {{W{1'b0}}, use_x & cc_in[XB]};
  assign ovf   = (dst[W-1] != src[W-1]) && (diff[W-1] != dst[W-1]);

  always_comb begin
    res_n = dst;
    cc_n  = cc_in;
    case (op)
      3'd0, 3'd1, 3'd4: begin
        res_n = (op == 3'd0) ? ~dst : (op == 3'd1) ? (src | dst) : {dst[H-1:0], dst[W-1:H]};
        cc_n[NB] = res_n[W-1];
        cc_n[ZB] = (res_n == '0);
        cc_n[VB] = 1'b0;
        cc_n[CB] = 1'b0;
      end
      3'd2, 3'd3: begin
        res_n = diff[W-1:0];
        cc_n[NB] = diff[W-1];
        cc_n[ZB] = use_x ? (cc_in[ZB] & (diff[W-1:0] == '0)) : (diff[W-1:0] == '0);
        cc_n[VB] = ovf;
        cc_n[CB] = diff[W];
        cc_n[XB] = diff[W];
      end
      3'd5: res_n = {dst[W-1:8], {8{cond_true}}};
      3'd6: begin
        res_n = dst | {{(W-8){1'b0}}, 8'h80};
        cc_n[NB] = dst[7];
        cc_n[ZB] = (dst[7:0] == 8'h00);
        cc_n[VB] = 1'b0;
        cc_n[CB] = 1'b0;
      end
      default: res_n = cc_in[VB] ? (dst[W-1] ? SMAX : SMIN) : dst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_n;
        cc_out <= cc_n;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cc_out)));
  // R6
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=> result == {$past(dst[H-1:0]), $past(dst[W-1:H])});
  // R7
  scc_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5) |=> cc_out == $past(cc_in));
  // R8
  tas_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd6) |=> (result[7] && result[W-1:8] == $past(dst[W-1:8])));
  // R9
  sat_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> cc_out == $past(cc_in));
  // R10
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 3'd0 || op == 3'd1 || op == 3'd4 || op == 3'd6))
      |=> (cc_out[VB] == 1'b0 && cc_out[CB] == 1'b0 && cc_out[XB] == $past(cc_in[XB])));
endmodule

// File: tb/test_long_int_unit.sv
module test_long_int_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src = '0, dst = '0;
  logic [4:0]  cc_in = '0;
  logic        cond_true = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  cc_out;
  int checks = 0, errors = 0;

  always #5ns clk = ~clk;

  long_int_unit i_long_int_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src), .dst(dst),
    .cc_in(cc_in), .cond_true(cond_true), .out_valid(out_valid), .result(result), .cc_out(cc_out));

  function automatic logic [36:0] model(input logic [2:0] o, input logic [31:0] s, input logic [31:0] d,
                                        input logic [4:0] c, input logic ct);
    logic [31:0] r;
    logic x, n, z, v, cy;
    longint unsigned sub;
    {x, n, z, v, cy} = c;
    r = d;
    case (o)
      3'd0: begin r = ~d; n = r[31]; z = (r == 0); v = 0; cy = 0; end
      3'd1: begin r = s | d; n = r[31]; z = (r == 0); v = 0; cy = 0; end
      3'd4: begin r = {d[15:0], d[31:16]}; n = r[31]; z = (r == 0); v = 0; cy = 0; end
      3'd2, 3'd3: begin
        sub = longint'(s) + ((o == 3'd3) ? longint'(c[4]) : 0);
        r = d - s - ((o == 3'd3) ? {31'd0, c[4]} : 32'd0);
        cy = (longint'(d) < sub);
        x = cy;
        n = r[31];
        v = (d[31] ^ s[31]) & (d[31] ^ r[31]);
        if (o == 3'd2) z = (r == 0);
        else if (r != 0) z = 0;
      end
      3'd5: r = {d[31:8], ct ? 8'hFF : 8'h00};
      3'd6: begin r = {d[31:8], 1'b1, d[6:0]}; n = d[7]; z = (d[7:0] == 0); v = 0; cy = 0; end
      default: if (c[1]) r = d[31] ? 32'h7FFFFFFF : 32'h80000000;
    endcase
    return {x, n, z, v, cy, r};
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R3/R10";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6/R10";
      3'd5: return "R7";
      3'd6: return "R8/R10";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input logic [2:0] o, input logic [31:0] s, input logic [31:0] d,
                     input logic [4:0] c, input logic ct);
    logic [36:0] exp;
    op = o; src = s; dst = d; cc_in = c; cond_true = ct; in_valid = 1'b1;
    exp = model(o, s, d, c, ct);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || {cc_out, result} != exp) begin
      errors++;
      $display("FAIL %s (R2 valid) op=%0d got v=%0b cc=%b res=%h expected v=1 cc=%b res=%h",
               tag(o), o, out_valid, cc_out, result, exp[36:32], exp[31:0]);
    end
  endtask

  initial begin
    #2ms;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [36:0] held;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid || result != 0 || cc_out != 0) begin
      errors++;
      $display("FAIL R1 got v=%0b res=%h cc=%b expected 0 0 0", out_valid, result, cc_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid || result != 0 || cc_out != 0) begin
      errors++;
      $display("FAIL R1 after release got v=%0b res=%h cc=%b expected 0 0 0", out_valid, result, cc_out);
    end
    // R3, R10
    run(3'd0, 32'h0, 32'hFFFFFFFF, 5'b10011, 1'b0);
    run(3'd1, 32'h80000000, 32'h00000001, 5'b00111, 1'b0);
    // R4
    run(3'd2, 32'h1, 32'h0, 5'b00000, 1'b0);
    run(3'd2, 32'h1, 32'h80000000, 5'b00000, 1'b0);
    run(3'd2, 32'h1234, 32'h1234, 5'b10000, 1'b0);
    // R5 sticky Z kept and cleared
    run(3'd3, 32'h0, 32'h1, 5'b10100, 1'b0);
    run(3'd3, 32'h0, 32'h1, 5'b10000, 1'b0);
    run(3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'b10100, 1'b0);
    // R6
    run(3'd4, 32'h0, 32'hABCD1234, 5'b00000, 1'b0);
    // R7
    run(3'd5, 32'h0, 32'h12345600, 5'b01010, 1'b1);
    run(3'd5, 32'h0, 32'h123456FF, 5'b01010, 1'b0);
    // R8
    run(3'd6, 32'h0, 32'hAA000000, 5'b10011, 1'b0);
    run(3'd6, 32'h0, 32'h00000080, 5'b00100, 1'b0);
    // R9
    run(3'd7, 32'h0, 32'h00000005, 5'b00010, 1'b0);
    run(3'd7, 32'h0, 32'h80000005, 5'b00010, 1'b0);
    run(3'd7, 32'h0, 32'h80000005, 5'b00000, 1'b0);
    // R2 hold
    held = {cc_out, result};
    op = 3'd0; dst = 32'h5555AAAA; cc_in = 5'b11111; in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    checks++;
    if (out_valid || {cc_out, result} != held) begin
      errors++;
      $display("FAIL R2 hold got v=%0b %h expected v=0 %h", out_valid, {cc_out, result}, held);
    end
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rs, rd;
      rs = $urandom;
      rd = $urandom;
      if (i % 9 == 0) rs = rd;
      run(3'($urandom_range(0, 7)), rs, rd, 5'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule